// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block accepts interrupt events from on-chip sources and stores each one as a 16-byte vector in a circular buffer in memory, where a host drains it. The host controls the block through a small register bus. Through that bus it sets the ring base, the ring size, the read and write pointers, the enables, the overflow handling and an optional write-pointer mirror address. The block raises a level interrupt while unread vectors remain. It detects the case where a new vector makes the ring look empty while data is unread, and it keeps a sticky flag for that case. The flag lives in the top bit of the write-pointer word.

One state machine runs the work. `ST_IDLE` waits for an event and accepts one only while the ring is enabled (transition *accept*). The walk `ST_DW0` → `ST_DW1` → `ST_DW2` → `ST_DW3` issues the four vector dwords (transition *step*). Leaving `ST_DW3` commits the write pointer. From there the machine goes to `ST_WB` when mirroring is on (transition *mirror*), or back to `ST_IDLE` when it is off (transition *done*). `ST_WB` stores the write-pointer word to the mirror address and then returns to `ST_IDLE`. A soft-reset pulse forces `ST_IDLE` from any state (transition *abort*).

Top module: `ivr_writer`

## Requirements
- R1: After reset, the following are all 0: every register, both pointers, the overflow flag, `host_irq`, `busy` and `ev_ready`.
- R2: A vector occupies four dword writes at addresses S, S+4, S+8 and S+12, where S = {BASE, 8'h00} + write pointer captured at acceptance. The dwords are, in order: {24'h0, src}, {4'h0, data}, {pasid, vm, ring} and 32'h0.
- R3: After each vector the write pointer becomes (wptr + 16) & mask. The byte mask is ((4 << size) - 1) with its low 4 bits cleared, and size is CTRL[9:5], the log2 of the ring length in dwords.
- R4: The overflow flag is set when all of these hold at the commit: overflow detection is on (CTRL[2]) and the advanced write pointer equals the read pointer. The vector is still written and the pointer still advances. The flag reads as bit 31 of the WPTR register (offset 3), above the pointer in the low bits.
- R5: A CTRL write with bit 4 set clears the flag. Bit 4 is not stored. If a new overflow is detected in the same cycle as a clear, the flag stays set.
- R6: When CTRL[3] is set, every vector is followed by one dword write. It goes to address {WB_HI[7:0], WB_LO} and carries the updated WPTR register value (flag and pointer).
- R7: `host_irq` equals CTRL[0] & CTRL[1] & ((rptr != wptr) | flag). It responds combinationally to host pointer writes.
- R8: `ev_ready` is high only in `ST_IDLE` with the ring enable CTRL[1] set. Events offered while it is low cause no memory write and leave the write pointer unchanged.
- R9: `busy` is high from acceptance until the last write of the vector. A `soft_rst` pulse returns the machine to `ST_IDLE` with no further writes, and the pointers and registers are kept.
- R10: Register offsets are CTRL 0, BASE 1 (address bits 39:8), RPTR 2, WPTR 3, WB_LO 4 and WB_HI 5. WB_HI keeps only 8 bits. `reg_rdata` shows the addressed register combinationally. Host pointer writes are masked with the ring mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| soft_rst | input | 1 | Synchronous return of the state machine to idle |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event accepted this cycle when valid |
| ev_src | input | 8 | Source id |
| ev_data | input | 28 | Source data |
| ev_ring | input | 8 | Ring id |
| ev_vm | input | 8 | VM id |
| ev_pasid | input | 16 | Process address-space id |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| mem_wr | output | 1 | Memory dword write strobe |
| mem_addr | output | 40 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| host_irq | output | 1 | Level interrupt to the host |
| busy | output | 1 | Vector in progress |

## Verification
Two functions can fall in the same cycle: overflow detection at the pointer commit, and a host clear of the overflow flag. The bench sets the pointers so that the next vector fills the ring. It then counts the negative edges after acceptance and drives the clearing CTRL write in the `ST_DW3` cycle, so the write lands on the commit edge. It expects the flag to survive, because a set wins over a clear. A later clear on its own must then remove the flag.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_DW0, ST_DW1, ST_DW2, ST_DW3, ST_WB
    } ivr_state_e;

    typedef struct packed {
        logic [15:0] pasid;
        logic [7:0]  vm;
        logic [7:0]  ring;
        logic [27:0] data;
        logic [7:0]  src;
    } ivr_vec_t;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_BASE = 3'd1;
    localparam logic [2:0] A_RPTR = 3'd2;
    localparam logic [2:0] A_WPTR = 3'd3;
    localparam logic [2:0] A_WBLO = 3'd4;
    localparam logic [2:0] A_WBHI = 3'd5;

    localparam int B_INTR   = 0;
    localparam int B_RING   = 1;
    localparam int B_OVFEN  = 2;
    localparam int B_WBEN   = 3;
    localparam int B_OVFCLR = 4;
    localparam int B_SZLO   = 5;
endpackage

// File: rtl/ivr_regs.sv
module ivr_regs
    import ivr_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             commit,
    output logic             intr_en,
    output logic             ring_en,
    output logic             wb_en,
    output logic [31:0]      base,
    output logic [39:0]      wb_addr,
    output logic [PTR_W-1:0] rptr,
    output logic [PTR_W-1:0] wptr,
    output logic             ovf
);
    logic [4:0]       size_q;
    logic             intr_q, ring_q, ovfen_q, wben_q, ovf_q;
    logic [31:0]      base_q, wblo_q;
    logic [7:0]       wbhi_q;
    logic [PTR_W-1:0] rptr_q, wptr_q;

    logic             ctrl_wr;
    logic             clr_req;
    logic [PTR_W-1:0] mask;
    logic [PTR_W-1:0] wptr_nxt;
    logic             ovf_hit;

    assign ctrl_wr  = reg_wr && (reg_addr == A_CTRL);
    assign clr_req  = ctrl_wr && reg_wdata[B_OVFCLR];
    assign mask     = ((PTR_W'(4) << size_q) - PTR_W'(1)) & ~PTR_W'(15);
    assign wptr_nxt = (wptr_q + PTR_W'(16)) & mask;
    assign ovf_hit  = commit && ovfen_q && (wptr_nxt == rptr_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q  <= '0;
            intr_q  <= 1'b0;
            ring_q  <= 1'b0;
            ovfen_q <= 1'b0;
            wben_q  <= 1'b0;
            base_q  <= '0;
            wblo_q  <= '0;
            wbhi_q  <= '0;
            rptr_q  <= '0;
            wptr_q  <= '0;
            ovf_q   <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                intr_q  <= reg_wdata[B_INTR];
                ring_q  <= reg_wdata[B_RING];
                ovfen_q <= reg_wdata[B_OVFEN];
                wben_q  <= reg_wdata[B_WBEN];
                size_q  <= reg_wdata[B_SZLO +: 5];
            end
            if (reg_wr && reg_addr == A_BASE) base_q <= reg_wdata;
            if (reg_wr && reg_addr == A_WBLO) wblo_q <= reg_wdata;
            if (reg_wr && reg_addr == A_WBHI) wbhi_q <= reg_wdata[7:0];
            if (reg_wr && reg_addr == A_RPTR) rptr_q <= PTR_W'(reg_wdata) & mask;
            if (commit)
                wptr_q <= wptr_nxt;
            else if (reg_wr && reg_addr == A_WPTR)
                wptr_q <= PTR_W'(reg_wdata) & mask;
            if (ovf_hit)
                ovf_q <= 1'b1;
            else if (clr_req)
                ovf_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_CTRL:  reg_rdata = {22'h0, size_q, 1'b0, wben_q, ovfen_q, ring_q, intr_q};
            A_BASE:  reg_rdata = base_q;
            A_RPTR:  reg_rdata = 32'(rptr_q);
            A_WPTR:  reg_rdata = {ovf_q, 31'(wptr_q)};
            A_WBLO:  reg_rdata = wblo_q;
            A_WBHI:  reg_rdata = {24'h0, wbhi_q};
            default: reg_rdata = 32'h0;
        endcase
    end

    assign intr_en = intr_q;
    assign ring_en = ring_q;
    assign wb_en   = wben_q;
    assign base    = base_q;
    assign wb_addr = {wbhi_q, wblo_q};
    assign rptr    = rptr_q;
    assign wptr    = wptr_q;
    assign ovf     = ovf_q;

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> wptr == (($past(wptr) + PTR_W'(16)) & $past(mask)));

    // R5
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr_req) |=> ovf);
endmodule

// File: rtl/ivr_fsm.sv
module ivr_fsm
    import ivr_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             ev_valid,
    input  ivr_vec_t         vec,
    output logic             ev_ready,
    input  logic             ring_en,
    input  logic             wb_en,
    input  logic [31:0]      base,
    input  logic [39:0]      wb_addr,
    input  logic [PTR_W-1:0] wptr,
    input  logic             ovf,
    output logic             commit,
    output logic             busy,
    output logic             mem_wr,
    output logic [39:0]      mem_addr,
    output logic [31:0]      mem_wdata
);
    ivr_state_e state_q, state_d;
    ivr_vec_t   vec_q;
    logic [39:0] slot_q;
    logic        accept;

    assign ev_ready = (state_q == ST_IDLE) && ring_en;
    assign accept   = ev_valid && ev_ready;
    assign busy     = (state_q != ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_DW0;
            ST_DW0:  state_d = ST_DW1;
            ST_DW1:  state_d = ST_DW2;
            ST_DW2:  state_d = ST_DW3;
            ST_DW3:  state_d = wb_en ? ST_WB : ST_IDLE;
            ST_WB:   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else if (soft_rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q  <= '0;
            slot_q <= '0;
        end else if (accept) begin
            vec_q  <= vec;
            slot_q <= {base, 8'h00} + 40'(wptr);
        end
    end

    always_comb begin
        mem_wr    = 1'b0;
        mem_addr  = slot_q;
        mem_wdata = 32'h0;
        commit    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DW0: begin
                mem_wr    = 1'b1;
                mem_wdata = {24'h0, vec_q.src};
            end
            ST_DW1: begin
                mem_wr    = 1'b1;
                mem_addr  = slot_q + 40'd4;
                mem_wdata = {4'h0, vec_q.data};
            end
            ST_DW2: begin
                mem_wr    = 1'b1;
                mem_addr  = slot_q + 40'd8;
                mem_wdata = {vec_q.pasid, vec_q.vm, vec_q.ring};
            end
            ST_DW3: begin
                mem_wr    = 1'b1;
                mem_addr  = slot_q + 40'd12;
                commit    = 1'b1;
            end
            ST_WB: begin
                mem_wr    = 1'b1;
                mem_addr  = wb_addr;
                mem_wdata = {ovf, 31'(wptr)};
            end
            default: ;
        endcase
    end

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (mem_wr && (state_q == ST_DW1 || state_q == ST_DW2 || state_q == ST_DW3))
        |-> mem_addr == $past(mem_addr) + 40'd4);

    // R6
    wb_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (state_q == ST_WB) |-> $past(commit));

    // R8
    accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ring_en));
endmodule

// File: rtl/ivr_writer.sv
module ivr_writer
    import ivr_pkg::*;
#(
    parameter int MAX_LOG2 = 14
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        ev_valid,
    output logic        ev_ready,
    input  logic [7:0]  ev_src,
    input  logic [27:0] ev_data,
    input  logic [7:0]  ev_ring,
    input  logic [7:0]  ev_vm,
    input  logic [15:0] ev_pasid,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_wr,
    output logic [39:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic        host_irq,
    output logic        busy
);
    localparam int PTR_W = MAX_LOG2 + 2;

    logic             commit, intr_en, ring_en, wb_en, ovf;
    logic [31:0]      base;
    logic [39:0]      wb_addr;
    logic [PTR_W-1:0] rptr, wptr;
    ivr_vec_t         vec;

    assign vec = '{pasid: ev_pasid, vm: ev_vm, ring: ev_ring, data: ev_data, src: ev_src};

    ivr_regs #(.PTR_W(PTR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .commit(commit), .intr_en(intr_en), .ring_en(ring_en), .wb_en(wb_en),
        .base(base), .wb_addr(wb_addr), .rptr(rptr), .wptr(wptr), .ovf(ovf)
    );

    ivr_fsm #(.PTR_W(PTR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .ev_valid(ev_valid), .vec(vec), .ev_ready(ev_ready),
        .ring_en(ring_en), .wb_en(wb_en), .base(base), .wb_addr(wb_addr),
        .wptr(wptr), .ovf(ovf), .commit(commit), .busy(busy),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    assign host_irq = intr_en && ring_en && ((rptr != wptr) || ovf);
endmodule

// File: tb/ivr_writer_bench.sv
module ivr_writer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        ev_valid = 1'b0;
    logic        ev_ready;
    logic [7:0]  ev_src = '0;
    logic [27:0] ev_data = '0;
    logic [7:0]  ev_ring = '0;
    logic [7:0]  ev_vm = '0;
    logic [15:0] ev_pasid = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_wr;
    logic [39:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        host_irq, busy;

    int nchk = 0;
    int nfail = 0;
    int nlog = 0;
    logic [39:0] log_a [64];
    logic [31:0] log_d [64];

    localparam logic [39:0] RING0 = 40'h80_0000_1200;
    localparam logic [39:0] WBA   = 40'hC1_0000_8000;

    always #2 clk = ~clk;

    ivr_writer u_ivr_writer (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_src(ev_src), .ev_data(ev_data),
        .ev_ring(ev_ring), .ev_vm(ev_vm), .ev_pasid(ev_pasid),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .host_irq(host_irq), .busy(busy)
    );

    always @(negedge clk) begin
        if (mem_wr && nlog < 64) begin
            log_a[nlog] = mem_addr;
            log_d[nlog] = mem_wdata;
            nlog = nlog + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic offer(input int k, input int s);
        ev_src = 8'(k * 3 + s); ev_data = 28'(k * 32'h1111 + s);
        ev_ring = 8'(k); ev_vm = 8'(s); ev_pasid = 16'(k * 257 + 1);
    endtask

    task automatic send(input int k, input int s);
        @(negedge clk);
        nlog = 0;
        offer(k, s);
        ev_valid = 1'b1;
        while (!ev_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    function automatic logic [31:0] ctl(input bit intr, input bit ring, input bit oe,
                                        input bit wb, input bit clr, input int s);
        return {22'h0, 5'(s), clr, wb, oe, ring, intr};
    endfunction

    initial begin
        #(4 * 200000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [15:0] wp, mask, nxt;
        logic        flag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(3'd3, r); chk(r == 0, "R1 wptr", r, 0);
        rd(3'd2, r); chk(r == 0, "R1 rptr", r, 0);
        rd(3'd0, r); chk(r == 0, "R1 ctrl", r, 0);
        chk(!host_irq && !busy && !ev_ready, "R1 outputs", {host_irq, busy, ev_ready}, 0);

        // R10 register map and WB_HI width
        wr(3'd5, 32'h3C1); rd(3'd5, r); chk(r == 32'hC1, "R10 wb_hi", r, 32'hC1);
        wr(3'd4, 32'h0000_8000);
        wr(3'd1, 32'h8000_0012); rd(3'd1, r); chk(r == 32'h8000_0012, "R10 base", r, 32'h8000_0012);

        // sweep over ring sizes
        for (int s = 3; s <= 5; s++) begin
            wr(3'd0, 0); wr(3'd2, 0); wr(3'd3, 0);
            wr(3'd0, ctl(1, 1, 1, 1, 1, s));
            mask = ((16'd4 << s) - 16'd1) & ~16'd15;
            wp = 0; flag = 0;
            for (int k = 0; k < (4 << s) / 16; k++) begin
                send(k, s);
                offer(k, s);
                nxt = (wp + 16'd16) & mask;
                chk(nlog == 5, "R6 write count", nlog, 5);
                for (int i = 0; i < 4; i++)
                    chk(log_a[i] == RING0 + 40'(wp) + 40'(4 * i), "R2 address", log_a[i], RING0 + 40'(wp) + 40'(4 * i));
                chk(log_d[0] == {24'h0, ev_src}, "R2 dw0", log_d[0], {24'h0, ev_src});
                chk(log_d[1] == {4'h0, ev_data}, "R2 dw1", log_d[1], {4'h0, ev_data});
                chk(log_d[2] == {ev_pasid, ev_vm, ev_ring}, "R2 dw2", log_d[2], {ev_pasid, ev_vm, ev_ring});
                chk(log_d[3] == 0, "R2 dw3", log_d[3], 0);
                if (nxt == 0) flag = 1;
                wp = nxt;
                rd(3'd3, r);
                chk(r == {flag, 15'h0, wp}, "R3 R4 wptr word", r, {flag, 15'h0, wp});
                chk(log_a[4] == WBA && log_d[4] == r, "R6 writeback", log_d[4], r);
                chk(host_irq, "R7 irq pending", host_irq, 1);
            end
            chk(flag == 1 && wp == 0, "R4 full ring wraps with flag", {flag, wp}, 1 << 16);
            wr(3'd0, ctl(1, 1, 1, 1, 1, s));
            rd(3'd3, r); chk(r == 0, "R5 clear", r, 0);
            chk(!host_irq, "R7 irq idle", host_irq, 0);
            wr(3'd2, 16);
            #1 chk(host_irq, "R7 irq after rptr write", host_irq, 1);
            wr(3'd2, 0);
            #1 chk(!host_irq, "R7 irq drop after rptr write", host_irq, 0);
        end

        // R5 collision: clear in the commit cycle of an overflowing vector
        wr(3'd0, ctl(1, 1, 1, 0, 1, 3));
        wr(3'd2, 0); wr(3'd3, 16);
        @(negedge clk);
        offer(7, 3);
        ev_valid = 1'b1;
        @(posedge clk);
        repeat (4) @(negedge clk);
        ev_valid = 1'b0;
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = ctl(1, 1, 1, 0, 1, 3);
        @(negedge clk);
        reg_wr = 1'b0;
        rd(3'd3, r); chk(r == 32'h8000_0000, "R5 set wins over clear", r, 32'h8000_0000);
        wr(3'd0, ctl(1, 1, 1, 0, 1, 3));
        rd(3'd3, r); chk(r == 0, "R5 later clear", r, 0);

        // R7 interrupt enable gates the line
        wr(3'd2, 16);
        wr(3'd0, ctl(0, 1, 1, 0, 0, 3));
        #1 chk(!host_irq, "R7 intr disabled", host_irq, 0);

        // R8 events ignored with ring disabled
        wr(3'd0, ctl(1, 0, 1, 0, 0, 3));
        @(negedge clk);
        nlog = 0;
        ev_valid = 1'b1;
        repeat (10) begin
            @(negedge clk);
            chk(!ev_ready, "R8 ready low", ev_ready, 0);
        end
        ev_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(nlog == 0 && !busy, "R8 no writes", nlog, 0);
        rd(3'd3, r); chk(r == 0, "R8 wptr unchanged", r, 0);

        // R9 soft reset mid vector
        wr(3'd0, ctl(1, 1, 1, 1, 0, 3));
        @(negedge clk);
        nlog = 0;
        offer(2, 3);
        ev_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
        chk(busy, "R9 busy after accept", busy, 1);
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        chk(!busy, "R9 idle after soft reset", busy, 0);
        repeat (6) @(negedge clk);
        chk(nlog == 2, "R9 no further writes", nlog, 2);
        rd(3'd3, r); chk(r == 0, "R9 wptr kept", r, 0);
        rd(3'd2, r); chk(r == 16, "R9 rptr kept", r, 16);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule